// File: doc/BRIEF.md
# Bank Coincidence Sync Pulse Generator

This block runs two divided clock banks, A and C, from one fast clock and drives an active-low warning output, `sync_n`. The warning goes low ahead of each rising edge that the two banks share. Each bank has its own 2-bit ratio select. The ratios need not divide one another: 3:2 and 4:3 relations work as well as integer ones. A downstream consumer can therefore tell which edge of the faster bank is the common one, because it sees the warning for one whole period of the faster bank before that edge happens.

All of the behaviour comes from counters in the fast-clock domain. Each bank has a divider counter. A coincidence counter runs modulo the least common multiple of the two ratios, and the warning window is decoded from it. Reset and any change of a ratio select restart all counters together, so the two banks always start with a shared rising edge.

Top module: `clkgen_bank_sync`

## Requirements
- R1: While `rst_n` is low, `bank_a_clk` and `bank_c_clk` are low and `sync_n` is high.
- R2: Bank A divides the fast clock by 4, 6, 8 or 12 for `sel_a` = 0, 1, 2, 3. Its output is high for the first half of each period, counted from its rising edge.
- R3: Bank C divides the fast clock by 2, 4, 6 or 8 for `sel_c` = 0, 1, 2, 3, with the same 50 % shape as bank A.
- R4: Both bank clocks rise together on the first fast-clock edge after reset is released, or after a restart (R9). This edge is cycle t = 0.
- R5: When the ratios differ, `sync_n` is low for exactly F fast cycles before each shared rising edge and high in every other cycle. F is the smaller of the two ratios.
- R6: `sync_n` is high in the cycle in which both bank clocks rise together.
- R7: When both ratios are equal, every rising edge is shared. `sync_n` is then high only in the cycles in which the banks rise and low in all other cycles.
- R8: `sync_n` stays high for the first L cycles after t = 0, where L is the least common multiple of the two ratios.
- R9: If either select differs from its value at the previous fast-clock edge, then at that edge both bank clocks go low, `sync_n` goes high, and the sequence restarts from R4 on the next edge with the new ratios.
- R10: Shared rising edges occur exactly when t is a multiple of L. No shared rising edge occurs between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock; every output changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a | input | 2 | Bank A ratio select |
| sel_c | input | 2 | Bank C ratio select |
| bank_a_clk | output | 1 | Regenerated bank A clock |
| bank_c_clk | output | 1 | Regenerated bank C clock |
| sync_n | output | 1 | Active-low warning of the next shared rising edge |

## Verification
A divider counter that is off by one shows up at once as a bank clock whose high or low phase has the wrong length. It also makes the shared rising edges drift away from multiples of L within one coincidence period. A wrong coincidence counter or a wrong window bound moves the low stretch of `sync_n` away from the F cycles just before a shared edge. A misplaced arming flag gives an early warning inside the first L cycles. All of these appear at the ports within at most two coincidence periods, which is 48 fast cycles at the largest ratio pair. The comparison is cycle by cycle, so a single misplaced cycle is reported.

// File: rtl/clkgen_sync_pkg.sv
package clkgen_sync_pkg;

  localparam int SEL_W      = 2;
  localparam int RATIO_MAX  = 12;
  localparam int PERIOD_MAX = 24;
  localparam int CNT_W      = $clog2(PERIOD_MAX + 1);
  localparam int NUM_BANKS  = 2;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SEL_W-1:0] sel_t;

  localparam cnt_t ONE = cnt_t'(1);

  // Bank A ratio: 4, 6, 8, 12
  function automatic cnt_t bank_a_div(input sel_t s);
    case (s)
      2'd0:    return cnt_t'(4);
      2'd1:    return cnt_t'(6);
      2'd2:    return cnt_t'(8);
      default: return cnt_t'(12);
    endcase
  endfunction

  // Bank C ratio: 2, 4, 6, 8
  function automatic cnt_t bank_c_div(input sel_t s);
    case (s)
      2'd0:    return cnt_t'(2);
      2'd1:    return cnt_t'(4);
      2'd2:    return cnt_t'(6);
      default: return cnt_t'(8);
    endcase
  endfunction

  // Smallest multiple of a that b divides; scanned downward so the
  // smallest match is the one left standing.
  function automatic cnt_t lcm_of(input cnt_t a, input cnt_t b);
    int unsigned res;
    res = int'(a) * int'(b);
    for (int k = RATIO_MAX; k >= 1; k--) begin
      if (b != '0 && ((int'(a) * k) % int'(b)) == 0) res = int'(a) * k;
    end
    return cnt_t'(res);
  endfunction

  function automatic cnt_t min_of(input cnt_t a, input cnt_t b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/clkgen_ratio_decode.sv
module clkgen_ratio_decode
  import clkgen_sync_pkg::*;
(
  input  sel_t sel_a,
  input  sel_t sel_c,
  output cnt_t ratio_a,
  output cnt_t ratio_c,
  output cnt_t period,
  output cnt_t fast
);

  always_comb begin
    ratio_a = bank_a_div(sel_a);
    ratio_c = bank_c_div(sel_c);
    period  = lcm_of(ratio_a, ratio_c);
    fast    = min_of(ratio_a, ratio_c);
  end

endmodule

// File: rtl/clkgen_bank_divider.sv
module clkgen_bank_divider
  import clkgen_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  cnt_t ratio,
  output logic clk_o,
  output cnt_t rem_o,
  output logic wrap_o
);

  cnt_t cnt_q, cnt_d;
  logic run_q, run_d, clk_d;
  cnt_t half;

  assign half   = ratio >> 1;
  // next edge is a rising edge of this bank
  assign wrap_o = run_q ? (cnt_q >= ratio - ONE) : 1'b1;
  // cycles left before the next rising edge, minus one
  assign rem_o  = run_q ? (ratio - ONE - cnt_q) : '0;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    clk_d = clk_o;
    if (restart) begin
      cnt_d = '0;
      run_d = 1'b0;
      clk_d = 1'b0;
    end else if (!run_q) begin
      cnt_d = '0;
      run_d = 1'b1;
      clk_d = 1'b1;
    end else begin
      cnt_d = wrap_o ? '0 : cnt_q + ONE;
      clk_d = (cnt_d < half);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      clk_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      clk_o <= clk_d;
    end
  end

  // R2 (and R3 for the bank C instance): a wrap is followed by a rising edge
  p_wrap_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wrap_o && !restart) |=> $rose(clk_o));

endmodule

// File: rtl/clkgen_coin_tracker.sv
module clkgen_coin_tracker
  import clkgen_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  cnt_t period,
  input  cnt_t fast,
  input  cnt_t rem_a,
  input  cnt_t rem_c,
  input  logic wrap_a,
  input  logic wrap_c,
  output logic sync_n
);

  cnt_t phase_q, phase_d;
  logic run_q, run_d;
  logic armed_q, armed_d;
  logic sync_d;
  logic phase_last;
  logic in_window_d;
  logic rems_equal;
  cnt_t win_start;

  assign win_start   = period - fast;
  assign phase_last  = (phase_q >= period - ONE);
  assign rems_equal  = (rem_a == rem_c);

  always_comb begin
    phase_d = phase_q;
    run_d   = run_q;
    armed_d = armed_q;
    if (restart) begin
      phase_d = '0;
      run_d   = 1'b0;
      armed_d = 1'b0;
    end else if (!run_q) begin
      phase_d = '0;
      run_d   = 1'b1;
      armed_d = 1'b0;
    end else begin
      phase_d = phase_last ? '0 : phase_q + ONE;
      armed_d = armed_q | (phase_d == '0);
    end
  end

  assign in_window_d = (phase_d >= win_start) && (phase_d != '0);
  assign sync_d      = !(run_d && armed_d && in_window_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      sync_n  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      run_q   <= run_d;
      armed_q <= armed_d;
      sync_n  <= sync_d;
    end
  end

  // R5: the window decoded from the phase counter agrees with the dividers
  p_predict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !restart) |-> ((phase_q >= win_start) == rems_equal));

  // R10: the phase counter wraps exactly when both banks rise together
  p_shared_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !restart) |-> ((wrap_a && wrap_c) == phase_last));

endmodule

// File: rtl/clkgen_bank_sync.sv
module clkgen_bank_sync
  import clkgen_sync_pkg::*;
(
  input  logic       clk_fast,
  input  logic       rst_n,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_c,
  output logic       bank_a_clk,
  output logic       bank_c_clk,
  output logic       sync_n
);

  sel_t sel_a_q, sel_c_q;
  logic restart;
  cnt_t ratio_a, ratio_c, period, fast;

  cnt_t ratio_v [NUM_BANKS];
  cnt_t rem_v   [NUM_BANKS];
  logic wrap_v  [NUM_BANKS];
  logic clk_v   [NUM_BANKS];

  // previous-edge copy of the selects, no reset needed: it only feeds restart
  always_ff @(posedge clk_fast) begin
    sel_a_q <= sel_a;
    sel_c_q <= sel_c;
  end

  assign restart = (sel_a != sel_a_q) || (sel_c != sel_c_q);

  clkgen_ratio_decode u_decode (
    .sel_a   (sel_a),
    .sel_c   (sel_c),
    .ratio_a (ratio_a),
    .ratio_c (ratio_c),
    .period  (period),
    .fast    (fast)
  );

  assign ratio_v[0] = ratio_a;
  assign ratio_v[1] = ratio_c;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    clkgen_bank_divider u_div (
      .clk     (clk_fast),
      .rst_n   (rst_n),
      .restart (restart),
      .ratio   (ratio_v[b]),
      .clk_o   (clk_v[b]),
      .rem_o   (rem_v[b]),
      .wrap_o  (wrap_v[b])
    );
  end

  assign bank_a_clk = clk_v[0];
  assign bank_c_clk = clk_v[1];

  clkgen_coin_tracker u_track (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .restart (restart),
    .period  (period),
    .fast    (fast),
    .rem_a   (rem_v[0]),
    .rem_c   (rem_v[1]),
    .wrap_a  (wrap_v[0]),
    .wrap_c  (wrap_v[1]),
    .sync_n  (sync_n)
  );

  // R1: reset state, sampled half a cycle after the edge
  always @(negedge clk_fast) begin
    if (!rst_n) begin
      p_reset_r1: assert (!bank_a_clk && !bank_c_clk && sync_n);
    end
  end

  // R6: warning is released on the shared rising edge
  p_high_at_edge_r6: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ($rose(bank_a_clk) && $rose(bank_c_clk)) |-> sync_n);

endmodule

// File: tb/clkgen_bank_sync_tb.sv
module clkgen_bank_sync_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel_a;
  logic [1:0] sel_c;
  logic       bank_a_clk, bank_c_clk, sync_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_bank_sync u_dut (
    .clk_fast   (clk),
    .rst_n      (rst_n),
    .sel_a      (sel_a),
    .sel_c      (sel_c),
    .bank_a_clk (bank_a_clk),
    .bank_c_clk (bank_c_clk),
    .sync_n     (sync_n)
  );

  typedef struct {
    logic  a;
    logic  c;
    logic  s;
    string ta;
    string tc;
    string ts;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int t_model = -1;
  logic [1:0] prev_a = 2'd0;
  logic [1:0] prev_c = 2'd0;

  function automatic int div_a(input logic [1:0] s);
    return (s == 2'd3) ? 12 : 4 + 2 * int'(s);
  endfunction

  function automatic int div_c(input logic [1:0] s);
    return 2 + 2 * int'(s);
  endfunction

  function automatic int gcd(input int x, input int y);
    int u = x;
    int v = y;
    while (v != 0) begin
      int r = u % v;
      u = v;
      v = r;
    end
    return u;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: models the edge, pushes the expectation, then sets next inputs.
  task automatic step(input logic r, input logic [1:0] na, input logic [1:0] nc);
    exp_t e;
    @(posedge clk);
    if (!rst_n) begin
      t_model = -1;
      e = '{1'b0, 1'b0, 1'b1, "R1", "R1", "R1"};
    end else if (sel_a != prev_a || sel_c != prev_c) begin
      t_model = -1;
      e = '{1'b0, 1'b0, 1'b1, "R9", "R9", "R9"};
    end else begin
      int ra, rc, l, f, ph;
      t_model++;
      ra = div_a(sel_a);
      rc = div_c(sel_c);
      l  = ra * rc / gcd(ra, rc);
      f  = (ra < rc) ? ra : rc;
      ph = t_model % l;
      e.a = ((t_model % ra) < ra / 2);
      e.c = ((t_model % rc) < rc / 2);
      e.s = !(t_model >= l && ph >= l - f && ph != 0);
      e.ta = (t_model == 0) ? "R4" : (ph == 0) ? "R10" : "R2";
      e.tc = (t_model == 0) ? "R4" : (ph == 0) ? "R10" : "R3";
      e.ts = (t_model < l) ? "R8" : (l == f) ? "R7" : (ph == 0) ? "R6" : "R5";
    end
    prev_a = sel_a;
    prev_c = sel_c;
    q.push_back(e);
    #1;
    rst_n = r;
    sel_a = na;
    sel_c = nc;
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(bank_a_clk, e.a, e.ta, "bank_a_clk");
        check(bank_c_clk, e.c, e.tc, "bank_c_clk");
        check(sync_n,     e.s, e.ts, "sync_n");
      end
    end
  end

  task automatic run_cfg(input logic [1:0] a, input logic [1:0] c, input int n);
    for (int i = 0; i < n; i++) step(1'b1, a, c);
  endtask

  initial begin
    int cfg_a [8] = '{2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd0, 2'd3};
    int cfg_c [8] = '{2'd3, 2'd0, 2'd0, 2'd1, 2'd2, 2'd2, 2'd2, 2'd3};
    rst_n = 1'b0;
    sel_a = 2'd0;
    sel_c = 2'd0;
    // reset, then release with ratios 4 and 2
    for (int i = 0; i < 3; i++) step(1'b0, 2'd0, 2'd0);
    step(1'b1, 2'd0, 2'd0);
    run_cfg(2'd0, 2'd0, 40);
    // live ratio changes, each restarting the sequence
    for (int k = 0; k < 8; k++) run_cfg(cfg_a[k][1:0], cfg_c[k][1:0], 80);
    // select change while in reset, then release
    for (int i = 0; i < 2; i++) step(1'b0, 2'd1, 2'd1);
    step(1'b0, 2'd2, 2'd1);
    step(1'b1, 2'd2, 2'd1);
    run_cfg(2'd2, 2'd1, 40);
    step(1'b1, 2'd2, 2'd1);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule